// File: doc/BRIEF.md
# Text-Mode Character Display Renderer

This block turns the pixel column and line counters of a 480x272 display timing source into a one-bit pixel stream for a text-only screen. The screen is a grid of 8x8 character cells, 60 cells across and 34 cells down. A character-code buffer holds one 8-bit code per cell. Each code selects one of 256 glyphs in a font lookup. The row and column of the current pixel inside its cell then pick one bit of that glyph.

The buffer has two ports. The display path only reads it. A host writes cell codes through a separate address, data and enable port while the display keeps running. The buffer is padded to 64x64 cells, so the cell index and the font index are both plain bit slices of the counters, with no multiply. Cells outside the 60x34 grid are stored but never shown. The buffer comes out of power-up already filled with a known pattern, so text is on screen before the host writes anything.

A separate registered window flag marks a horizontal band of the counter. Exact counter matches set and clear it; no range compare is used.

Top module: `text_renderer`

## Requirements
- R1: The cell shown at counters (x, y) is the buffer entry at index {y[8:3], x[8:3]}: the cell column is in the low six index bits and the cell row in the high six.
- R2: The glyph for code k, at glyph row r = y[2:0] and glyph column c = x[2:0], gives the pixel value bit (c XOR r) of k, inverted when r is 4 or more. The font index is {k, r, c}.
- R3: `pix_out` is valid two clock edges after the counters are presented. The glyph row and column travel through both stages with the code, so each pixel matches its own glyph position.
- R4: `pix_out` is 0 for every position with x >= 480 or y >= 272.
- R5: Before any host write, the cell at column c and row r holds the code (c + 3*r) mod 256.
- R6: A host write of code d to index a changes what is displayed for that cell on every later read, including the next frame.
- R7: When a host write and a display read hit the same cell on the same edge, the read returns the old code. The new code is read from the next edge on.
- R8: `hl_out` is 1 on the cycle after the horizontal counter equals 482.
- R9: `hl_out` is 0 on the cycle after the horizontal counter equals 523. At any other counter value it keeps its previous value.
- R10: While `rst_n` is low, and on the first cycle after it is released, `pix_out` and `hl_out` are 0.
- R11: Codes written to cells beyond column 59 or row 33 never reach `pix_out`. For example, a code of 0xFF at column 60 still gives 0 for x in 480..487.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low reset for the pipeline and window flag |
| pix_x | input | 10 | Horizontal pixel counter, 0 at first visible column |
| pix_y | input | 10 | Vertical line counter, 0 at first visible line |
| wr_en | input | 1 | Host write enable for the character buffer |
| wr_addr | input | 12 | Host cell index, {row[5:0], column[5:0]} |
| wr_code | input | 8 | Character code to store |
| pix_out | output | 1 | Rendered pixel, two cycles behind the counters |
| hl_out | output | 1 | Registered highlight window flag |

## Verification
The hardest case to reach from the ports is a host write that lands on the very cell the display path reads on the same edge. It needs the write timed to the exact cycle on which the counters enter that cell. The stimulus walks one character row pixel by pixel and raises the write enable on the tick that presents the first pixel of a chosen cell. The scoreboard expects the old glyph on that pixel and the new glyph on the following pixels and on a later rescan. A full frame after a write to a visible cell and to a hidden column-60 cell checks every visible pixel and the blanked pixels beside it.

// File: rtl/text_pkg.sv
package text_pkg;
  localparam int CODE_W   = 8;
  localparam int GLYPH_LG = 3;
  localparam int CELL_LG  = 6;
  localparam int BUF_AW   = 2 * CELL_LG;
  localparam int FONT_AW  = CODE_W + 2 * GLYPH_LG;

  // cell index: column in low bits, row in high bits
  function automatic logic [BUF_AW-1:0] cell_index(input logic [CELL_LG-1:0] col,
                                                   input logic [CELL_LG-1:0] row);
    return {row, col};
  endfunction

  // power-up code of a cell: column plus three times row, wrapped
  function automatic logic [CODE_W-1:0] boot_code(input logic [BUF_AW-1:0] idx);
    logic [CODE_W-1:0] c;
    logic [CODE_W-1:0] r;
    c = CODE_W'(idx[CELL_LG-1:0]);
    r = CODE_W'(idx[BUF_AW-1:CELL_LG]);
    return c + r + r + r;
  endfunction

  function automatic logic [FONT_AW-1:0] font_index(input logic [CODE_W-1:0] code,
                                                    input logic [GLYPH_LG-1:0] row,
                                                    input logic [GLYPH_LG-1:0] col);
    return {code, row, col};
  endfunction

  // computed glyph set: bit (col xor row) of the code, inverted in the lower half
  function automatic logic glyph_pixel(input logic [FONT_AW-1:0] fa);
    logic [CODE_W-1:0]   code;
    logic [GLYPH_LG-1:0] r;
    logic [GLYPH_LG-1:0] c;
    code = fa[FONT_AW-1 -: CODE_W];
    r    = fa[2*GLYPH_LG-1:GLYPH_LG];
    c    = fa[GLYPH_LG-1:0];
    return code[c ^ r] ^ r[GLYPH_LG-1];
  endfunction
endpackage

// File: rtl/char_buffer.sv
module char_buffer import text_pkg::*; #(
  parameter int AW = BUF_AW,
  parameter int DW = CODE_W
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = DW'(boot_code(BUF_AW'(i)));
  end

  // read before write on a shared cell: the read sees the stored value
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/font_rom.sv
module font_rom import text_pkg::*; (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FONT_AW-1:0] addr,
  input  logic               vis,
  output logic               pix
);
  logic bit_now;

  always_comb bit_now = glyph_pixel(addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pix <= 1'b0;
    else        pix <= vis & bit_now;
  end
endmodule

// File: rtl/hilite_window.sv
module hilite_window #(
  parameter int X_W = 10,
  parameter int ON  = 482,
  parameter int OFF = 523
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [X_W-1:0] x,
  output logic           flag
);
  logic set_hit;
  logic clr_hit;

  always_comb begin
    set_hit = (x == X_W'(ON));
    clr_hit = (x == X_W'(OFF));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (set_hit) flag <= 1'b1;
    else if (clr_hit) flag <= 1'b0;
  end
endmodule

// File: rtl/text_renderer.sv
module text_renderer import text_pkg::*; #(
  parameter int X_W    = 10,
  parameter int Y_W    = 10,
  parameter int VIS_W  = 480,
  parameter int VIS_H  = 272,
  parameter int HL_ON  = 482,
  parameter int HL_OFF = 523
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [X_W-1:0]    pix_x,
  input  logic [Y_W-1:0]    pix_y,
  input  logic              wr_en,
  input  logic [BUF_AW-1:0] wr_addr,
  input  logic [CODE_W-1:0] wr_code,
  output logic              pix_out,
  output logic              hl_out
);
  localparam int GL = GLYPH_LG;
  localparam int CL = CELL_LG;

  logic              vis_d0;
  logic              vis_d1;
  logic [GL-1:0]     xlo_d1;
  logic [GL-1:0]     ylo_d1;
  logic [BUF_AW-1:0] rd_addr;
  logic [CODE_W-1:0] rd_code;
  logic [FONT_AW-1:0] font_addr;

  always_comb begin
    vis_d0  = (pix_x < X_W'(VIS_W)) && (pix_y < Y_W'(VIS_H));
    rd_addr = cell_index(pix_x[GL +: CL], pix_y[GL +: CL]);
  end

  // stage 1: glyph position and visibility travel beside the buffer read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vis_d1 <= 1'b0;
      xlo_d1 <= '0;
      ylo_d1 <= '0;
    end else begin
      vis_d1 <= vis_d0;
      xlo_d1 <= pix_x[GL-1:0];
      ylo_d1 <= pix_y[GL-1:0];
    end
  end

  char_buffer #(.AW(BUF_AW), .DW(CODE_W)) u_buf (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_code),
    .rd_addr (rd_addr),
    .rd_data (rd_code)
  );

  always_comb font_addr = font_index(rd_code, ylo_d1, xlo_d1);

  // stage 2: glyph bit, forced low outside the visible area
  font_rom u_font (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (font_addr),
    .vis   (vis_d1),
    .pix   (pix_out)
  );

  hilite_window #(.X_W(X_W), .ON(HL_ON), .OFF(HL_OFF)) u_hl (
    .clk   (clk),
    .rst_n (rst_n),
    .x     (pix_x),
    .flag  (hl_out)
  );
endmodule

// File: rtl/text_renderer_chk.sv
module text_renderer_chk import text_pkg::*; #(
  parameter int X_W    = 10,
  parameter int Y_W    = 10,
  parameter int HL_ON  = 482,
  parameter int HL_OFF = 523
) (
  input logic              clk,
  input logic              rst_n,
  input logic [X_W-1:0]    pix_x,
  input logic [Y_W-1:0]    pix_y,
  input logic              wr_en,
  input logic [BUF_AW-1:0] wr_addr,
  input logic [CODE_W-1:0] wr_code,
  input logic              pix_out,
  input logic              hl_out,
  input logic [BUF_AW-1:0] rd_addr,
  input logic [CODE_W-1:0] rd_code,
  input logic              vis_d1
);
  // R4: a blank position in stage 1 yields a dark pixel
  p_blank_dark_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !vis_d1 |=> !pix_out);

  // R8: window opens after the set column
  p_hl_open_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_x == X_W'(HL_ON)) |=> hl_out);

  // R9: window closes after the clear column
  p_hl_close_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_x == X_W'(HL_OFF)) |=> !hl_out);

  // R9: flag holds at every other column
  p_hl_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_x != X_W'(HL_ON) && pix_x != X_W'(HL_OFF)) |=> $stable(hl_out));

  // R6: a written code is returned by a read of that cell on the next edge
  p_write_seen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en ##1 (rd_addr == $past(wr_addr) && !(wr_en && wr_addr == rd_addr))
    |=> rd_code == $past(wr_code, 2));

  logic unused_ok;
  always_comb unused_ok = ^pix_y;
endmodule

bind text_renderer text_renderer_chk #(
  .X_W(X_W), .Y_W(Y_W), .HL_ON(HL_ON), .HL_OFF(HL_OFF)
) u_chk (.*);

// File: tb/text_renderer_tb.sv
module text_renderer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 195000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  pix_x = '0;
  logic [9:0]  pix_y = '0;
  logic        wr_en = 1'b0;
  logic [11:0] wr_addr = '0;
  logic [7:0]  wr_code = '0;
  logic        pix_out;
  logic        hl_out;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  byte unsigned ref_mem [4096];
  bit    exp_q [$];
  string tag_q [$];
  bit    hl_model = 0;
  bit    hl_valid = 0;

  text_renderer u_dut (
    .clk(clk), .rst_n(rst_n), .pix_x(pix_x), .pix_y(pix_y),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_code(wr_code),
    .pix_out(pix_out), .hl_out(hl_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WD_LIMIT) begin
      total++; bad++;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<%0d", cyc, WD_LIMIT);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // reference: cell = (y/8)*64 + x/8, pixel = bit (c^r) of code, inverted for r>=4
  function automatic bit ref_pixel(int x, int y);
    int code, r, c;
    if (x >= 480 || y >= 272) return 0;
    code = ref_mem[(y / 8) * 64 + (x / 8)];
    r = y % 8;
    c = x % 8;
    return bit'(((code >> (c ^ r)) & 1) ^ (r >= 4 ? 1 : 0));
  endfunction

  task automatic check_bit(string tag, bit act, bit exp, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  // one pixel clock: monitor compares, driver presents and pushes the expectation
  task automatic tick(int x, int y, bit w, int a, int d, string tag);
    @(negedge clk);
    if (exp_q.size() == 2) check_bit(tag_q.pop_front(), pix_out, exp_q.pop_front(), "pix_out");
    if (hl_valid) check_bit(hl_model ? "R8" : "R9", hl_out, hl_model, "hl_out");
    pix_x   = 10'(x);
    pix_y   = 10'(y);
    wr_en   = w;
    wr_addr = 12'(a);
    wr_code = 8'(d);
    exp_q.push_back(ref_pixel(x, y));
    tag_q.push_back(tag);
    if (x == 482) hl_model = 1;
    else if (x == 523) hl_model = 0;
    hl_valid = 1;
    if (w) ref_mem[a] = byte'(d);
  endtask

  task automatic host_write(int a, int d);
    tick(600, 300, 1'b1, a, d, "R6");
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) ref_mem[i] = byte'(((i % 64) + 3 * (i / 64)) % 256);
    pix_x = 10'd600;
    pix_y = 10'd300;
    repeat (3) @(negedge clk);
    // R10: outputs low in reset
    check_bit("R10", pix_out, 1'b0, "pix_out in reset");
    check_bit("R10", hl_out, 1'b0, "hl_out in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_bit("R10", pix_out, 1'b0, "pix_out after reset");
    check_bit("R10", hl_out, 1'b0, "hl_out after reset");

    // R5: power-up contents on the first character rows
    for (int y = 0; y < 16; y++)
      for (int x = 0; x < 40; x++) tick(x, y, 1'b0, 0, 0, "R5");

    // R4: corner around the visible edge
    for (int y = 268; y < 276; y++)
      for (int x = 470; x < 492; x++) tick(x, y, 1'b0, 0, 0, "R4");

    // R8 R9: window set, hold, clear, hold
    tick(481, 0, 1'b0, 0, 0, "R4");
    tick(482, 0, 1'b0, 0, 0, "R4");
    tick(100, 0, 1'b0, 0, 0, "R8");
    tick(200, 0, 1'b0, 0, 0, "R8");
    tick(522, 0, 1'b0, 0, 0, "R4");
    tick(523, 0, 1'b0, 0, 0, "R4");
    tick(300, 0, 1'b0, 0, 0, "R9");
    tick(482, 5, 1'b0, 0, 0, "R4");
    tick(482, 6, 1'b0, 0, 0, "R4");

    // R6 R11: host writes, a visible cell and a hidden column-60 cell
    host_write(2 * 64 + 5, 8'hA5);
    host_write(2 * 64 + 60, 8'hFF);
    host_write(33 * 64 + 59, 8'h5A);
    host_write(40 * 64 + 10, 8'hFF);

    // R1 R2 R3 R4 R6 R11: full frame plus blank margin
    for (int y = 0; y < 274; y++)
      for (int x = 0; x < 488; x++)
        tick(x, y, 1'b0, 0, 0, (x >= 480 || y >= 272) ? "R4 R11" : "R1 R2 R3 R6");

    // R7: write lands on the cell being read on the same edge
    for (int x = 0; x < 48; x++)
      tick(x, 8, x == 16, 1 * 64 + 2, 8'h3C, (x == 16) ? "R7" : "R3");
    for (int y = 8; y < 16; y++)
      for (int x = 8; x < 32; x++) tick(x, y, 1'b0, 0, 0, "R6 R7");

    // flush pipeline
    tick(600, 300, 1'b0, 0, 0, "R4");
    tick(600, 300, 1'b0, 0, 0, "R4");
    tick(600, 300, 1'b0, 0, 0, "R4");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule